// File: doc/BRIEF.md
# Banked Bitmap Raster Scanner

This block turns a one-bit-per-pixel picture of 256 columns by 192 lines into a serial pixel stream with line and frame sync pulses. The picture is held in twelve small banks of 64 by 64 cells. The banks form three horizontal bands of four banks each. One free-running binary counter sets all of the timing. A bank is slower than one pixel time, so each bank access reads the same cell from the four banks of a band at once. That gives four adjacent pixels. Two four-bit holding registers take turns: one fills from the banks while the other is shifted out.

A host changes the picture one pixel at a time. A write is held until the scan reaches the fetch slot that covers its cell. That read slot then becomes a write slot, and the new value also goes straight to the display. A clear command keeps every bank in write mode for one full counter period, so every visible pixel ends at the chosen level. A static origin control selects whether line 0 of the stored picture is shown at the top or at the bottom of the screen.

Top module: `raster_scanner`

## Requirements
- R1: Pixel (x, y) is stored in band y[7:6] (0 to 2), lane bank x[1:0], at in-bank row y[5:0] and in-bank column x[7:2]. With the origin at the top, it appears at scan column x of scan line y.
- R2: While `rst` is high, `video`, `line_sync`, `frame_sync`, `wr_done` and `clr_busy` are 0 and `wr_ready` is 1.
- R3: A 16-bit scan count advances by one per clock. The output beat for count c shows column c[7:0] of line c[15:8]. Lines 192 to 255 are blanking lines, and `video` is 0 on them.
- R4: `line_sync` is a one-cycle pulse on the beat for column 0 of every line, so it comes every 256 cycles. `frame_sync` is a one-cycle pulse on the beat for count 0, once per 65,536 cycles, and it always coincides with `line_sync`.
- R5: A bank access every fourth cycle delivers four pixels. The two holding registers alternate, so the stream shows the stored picture with no gap or repeated pixel.
- R6: A write is accepted when `wr_valid` and `wr_ready` are both high. `wr_ready` stays low until the write is committed. `wr_done` is a one-cycle pulse that comes no more than one counter period plus two cycles after acceptance.
- R7: A committed write stores `wr_val` (1 bright, 0 dark). A later write to the same pixel replaces an earlier one, and neighbouring pixels in the same lane group keep their values.
- R8: A write whose y lies in the blanking lines (192 to 255) is still acknowledged, but it changes no visible pixel.
- R9: `clr_go` while idle starts a clear. `clr_busy` is then high for exactly 65,536 cycles, after which every visible pixel equals the `clr_lvl` sampled at the start. A `clr_go` during a clear has no effect, including a different level.
- R10: A write accepted during a clear is not committed while `clr_busy` is high. It commits after the clear, so its value survives.
- R11: With `origin_bottom` high, scan line s (0 to 191) shows stored line 191 - s. Blanking lines stay dark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one pixel per cycle |
| rst | input | 1 | Synchronous active-high reset |
| origin_bottom | input | 1 | 1: stored line 0 is shown at the bottom of the screen |
| wr_valid | input | 1 | Pixel write request |
| wr_x | input | 8 | Write column |
| wr_y | input | 8 | Write line; values 192 to 255 are dropped |
| wr_val | input | 1 | Pixel value to store |
| wr_ready | output | 1 | No write is pending |
| wr_done | output | 1 | One-cycle pulse when the pending write has been committed |
| clr_go | input | 1 | Start a whole-picture clear |
| clr_lvl | input | 1 | Level written by the clear |
| clr_busy | output | 1 | A clear is running |
| video | output | 1 | Serial pixel stream |
| line_sync | output | 1 | Line start pulse |
| frame_sync | output | 1 | Frame start pulse |

## Verification
The bench first checks whole frames after a bright clear and after a dark clear. This separates a correct clear and blank band from a stuck or lagging pair of holding registers. It then writes sparse pixels at the four corners, in every lane position and on both sides of each band edge. These show whether the lane, band and column mapping is right and whether the two registers swap correctly. It also overwrites a pixel next to a neighbour, which separates a per-lane write enable from a whole-group write. Writes into the blanking lines, and a write issued in the middle of a clear, show whether out-of-range commands are dropped and whether a pending write is deferred until the clear ends. A final frame taken with the bottom origin must show the same picture mirrored line for line.

// File: rtl/raster_pkg.sv
package raster_pkg;

    // Four banks per band: one access yields four adjacent pixels
    localparam int unsigned LANES  = 4;
    localparam int unsigned LANE_W = 2;

    // Three live bands; band code 3 is the blanking region
    localparam int unsigned BANDS  = 3;
    localparam int unsigned BAND_W = 2;

    typedef enum logic [0:0] {
        PLOT_IDLE = 1'b0,
        PLOT_WAIT = 1'b1
    } plot_state_e;

    typedef struct packed {
        logic pix;
        logic line;
        logic frame;
    } beat_t;

    function automatic logic band_live(input logic [BAND_W-1:0] band);
        return band < BAND_W'(BANDS);
    endfunction

    function automatic logic [BAND_W-1:0] band_mirror(input logic [BAND_W-1:0] band);
        return BAND_W'(BANDS - 1) - band;
    endfunction

    function automatic logic [LANES-1:0] lane_onehot(input logic [LANE_W-1:0] lane);
        return LANES'(1) << lane;
    endfunction

endpackage

// File: rtl/scan_timer.sv
module scan_timer
    import raster_pkg::*;
#(
    parameter int unsigned IB = 6
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              flip,
    output logic              fetch_stb,
    output logic              fetch_slot,
    output logic [BAND_W-1:0] fetch_band,
    output logic [IB-1:0]     fetch_row,
    output logic [IB-1:0]     fetch_col,
    output logic [LANE_W-1:0] cur_phase,
    output logic              cur_slot,
    output logic              cur_live,
    output logic              line_start,
    output logic              frame_start
);
    localparam int unsigned XW = IB + LANE_W;
    localparam int unsigned CW = 2 * IB + LANE_W + BAND_W;
    localparam int unsigned GW = CW - LANE_W;

    logic [CW-1:0]     cnt_q;
    logic [GW-1:0]     next_grp;
    logic [BAND_W-1:0] next_band;
    logic [IB-1:0]     next_row;
    logic              next_live;

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_q + CW'(1);
    end

    // Group that follows the one now being shifted out
    assign next_grp  = cnt_q[CW-1:LANE_W] + GW'(1);
    assign next_band = next_grp[GW-1 -: BAND_W];
    assign next_row  = next_grp[IB +: IB];
    assign next_live = band_live(next_band);

    assign fetch_col  = next_grp[IB-1:0];
    assign fetch_slot = next_grp[0];
    assign fetch_band = (flip && next_live) ? band_mirror(next_band) : next_band;
    assign fetch_row  = (flip && next_live) ? ~next_row : next_row;
    assign fetch_stb  = &cnt_q[LANE_W-1:0];

    assign cur_phase   = cnt_q[LANE_W-1:0];
    assign cur_slot    = cnt_q[LANE_W];
    assign cur_live    = band_live(cnt_q[CW-1 -: BAND_W]);
    assign line_start  = (cnt_q[XW-1:0] == '0);
    assign frame_start = (cnt_q == '0);

    // R5: a fetch always sits on the last phase of a group
    p_fetch_closes_group_r5: assert property (@(posedge clk) disable iff (rst)
        fetch_stb |=> (cur_phase == '0));

endmodule

// File: rtl/bank_store.sv
module bank_store
    import raster_pkg::*;
#(
    parameter int unsigned IB = 6
)(
    input  logic              clk,
    input  logic              fetch_stb,
    input  logic [BAND_W-1:0] band,
    input  logic [IB-1:0]     row,
    input  logic [IB-1:0]     col,
    input  logic [LANES-1:0]  we,
    input  logic [LANES-1:0]  wdata,
    output logic [LANES-1:0]  rdata
);
    localparam int unsigned DIM = 1 << IB;

    logic [BANDS*LANES-1:0] rd_bit;

    for (genvar gb = 0; gb < BANDS; gb++) begin : g_band
        for (genvar gl = 0; gl < LANES; gl++) begin : g_lane
            logic [DIM-1:0] cells [DIM];

            // The read slot becomes a write slot for the selected banks
            always_ff @(posedge clk) begin
                if (fetch_stb && band == BAND_W'(gb) && we[gl])
                    cells[row][col] <= wdata[gl];
            end

            assign rd_bit[gb*LANES + gl] = cells[row][col];
        end
    end

    // Band select, with write-through so the display sees new data at once
    always_comb begin
        rdata = '0;
        for (int b = 0; b < BANDS; b++) begin
            if (band == BAND_W'(b)) rdata = rd_bit[b*LANES +: LANES];
        end
        for (int l = 0; l < LANES; l++) begin
            if (we[l]) rdata[l] = wdata[l];
        end
    end

endmodule

// File: rtl/pixel_shifter.sv
module pixel_shifter
    import raster_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fetch_stb,
    input  logic              fetch_slot,
    input  logic [LANES-1:0]  fill,
    input  logic [LANE_W-1:0] cur_phase,
    input  logic              cur_slot,
    input  logic              cur_live,
    input  logic              line_start,
    input  logic              frame_start,
    output beat_t             beat
);
    logic [LANES-1:0] hold_q [2];

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q[0] <= '0;
            hold_q[1] <= '0;
            beat      <= '0;
        end else begin
            if (fetch_stb) hold_q[fetch_slot] <= fill;
            beat.pix   <= cur_live & hold_q[cur_slot][cur_phase];
            beat.line  <= line_start;
            beat.frame <= frame_start;
        end
    end

    // R5: the register being filled is never the one being shifted out
    p_fill_idle_slot_r5: assert property (@(posedge clk) disable iff (rst)
        fetch_stb |-> (fetch_slot != cur_slot));

endmodule

// File: rtl/plot_ctrl.sv
module plot_ctrl
    import raster_pkg::*;
#(
    parameter int unsigned IB = 6
)(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_valid,
    input  logic [IB+LANE_W-1:0]   wr_x,
    input  logic [IB+BAND_W-1:0]   wr_y,
    input  logic                   wr_val,
    output logic                   wr_ready,
    output logic                   wr_done,
    input  logic                   clr_go,
    input  logic                   clr_lvl,
    output logic                   clr_busy,
    input  logic                   fetch_stb,
    input  logic [BAND_W-1:0]      fetch_band,
    input  logic [IB-1:0]          fetch_row,
    input  logic [IB-1:0]          fetch_col,
    output logic [LANES-1:0]       we,
    output logic [LANES-1:0]       wdata
);
    localparam int unsigned CW = 2 * IB + LANE_W + BAND_W;

    typedef struct packed {
        logic [BAND_W-1:0] band;
        logic [IB-1:0]     row;
        logic [IB-1:0]     col;
        logic [LANE_W-1:0] lane;
        logic              val;
    } target_t;

    plot_state_e   st_q;
    target_t       tgt_q;
    logic          clr_busy_q;
    logic          clr_lvl_q;
    logic [CW-1:0] clr_cnt_q;
    logic          slot_match;
    logic          commit;

    assign slot_match = (fetch_band == tgt_q.band) && (fetch_row == tgt_q.row) &&
                        (fetch_col == tgt_q.col);
    assign commit     = (st_q == PLOT_WAIT) && !clr_busy_q && fetch_stb && slot_match;
    assign wr_ready   = (st_q == PLOT_IDLE);
    assign clr_busy   = clr_busy_q;

    always_comb begin
        we    = '0;
        wdata = '0;
        if (clr_busy_q) begin
            we    = '1;
            wdata = {LANES{clr_lvl_q}};
        end else if (st_q == PLOT_WAIT && slot_match) begin
            we    = lane_onehot(tgt_q.lane);
            wdata = {LANES{tgt_q.val}};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= PLOT_IDLE;
            tgt_q      <= '0;
            wr_done    <= 1'b0;
            clr_busy_q <= 1'b0;
            clr_lvl_q  <= 1'b0;
            clr_cnt_q  <= '0;
        end else begin
            wr_done <= commit;
            if (commit) begin
                st_q <= PLOT_IDLE;
            end else if (st_q == PLOT_IDLE && wr_valid) begin
                st_q       <= PLOT_WAIT;
                tgt_q.band <= wr_y[IB+BAND_W-1 -: BAND_W];
                tgt_q.row  <= wr_y[IB-1:0];
                tgt_q.col  <= wr_x[IB+LANE_W-1:LANE_W];
                tgt_q.lane <= wr_x[LANE_W-1:0];
                tgt_q.val  <= wr_val;
            end

            if (!clr_busy_q) begin
                if (clr_go) begin
                    clr_busy_q <= 1'b1;
                    clr_lvl_q  <= clr_lvl;
                    clr_cnt_q  <= '0;
                end
            end else begin
                clr_cnt_q <= clr_cnt_q + CW'(1);
                if (&clr_cnt_q) clr_busy_q <= 1'b0;
            end
        end
    end

    // R6: an acknowledge only follows a pending write
    p_done_after_wait_r6: assert property (@(posedge clk) disable iff (rst)
        wr_done |-> ($past(st_q) == PLOT_WAIT));

    // R6: a pending target does not move until it commits
    p_target_held_r6: assert property (@(posedge clk) disable iff (rst)
        (st_q == PLOT_WAIT && !commit) |=> (st_q == PLOT_WAIT && $stable(tgt_q)));

    // R10: no write commits while the clear owns the banks
    p_no_commit_in_clear_r10: assert property (@(posedge clk) disable iff (rst)
        wr_done |-> !$past(clr_busy_q));

endmodule

// File: rtl/raster_scanner.sv
module raster_scanner
    import raster_pkg::*;
#(
    parameter int unsigned IB_BITS = 6
)(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      origin_bottom,
    input  logic                      wr_valid,
    input  logic [IB_BITS+LANE_W-1:0] wr_x,
    input  logic [IB_BITS+BAND_W-1:0] wr_y,
    input  logic                      wr_val,
    output logic                      wr_ready,
    output logic                      wr_done,
    input  logic                      clr_go,
    input  logic                      clr_lvl,
    output logic                      clr_busy,
    output logic                      video,
    output logic                      line_sync,
    output logic                      frame_sync
);
    logic              fetch_stb;
    logic              fetch_slot;
    logic [BAND_W-1:0] fetch_band;
    logic [IB_BITS-1:0] fetch_row;
    logic [IB_BITS-1:0] fetch_col;
    logic [LANE_W-1:0] cur_phase;
    logic              cur_slot;
    logic              cur_live;
    logic              line_start;
    logic              frame_start;
    logic [LANES-1:0]  bank_we;
    logic [LANES-1:0]  bank_wdata;
    logic [LANES-1:0]  bank_rdata;
    beat_t             beat;

    scan_timer #(.IB(IB_BITS)) u_timer (
        .clk         (clk),
        .rst         (rst),
        .flip        (origin_bottom),
        .fetch_stb   (fetch_stb),
        .fetch_slot  (fetch_slot),
        .fetch_band  (fetch_band),
        .fetch_row   (fetch_row),
        .fetch_col   (fetch_col),
        .cur_phase   (cur_phase),
        .cur_slot    (cur_slot),
        .cur_live    (cur_live),
        .line_start  (line_start),
        .frame_start (frame_start)
    );

    plot_ctrl #(.IB(IB_BITS)) u_plot (
        .clk        (clk),
        .rst        (rst),
        .wr_valid   (wr_valid),
        .wr_x       (wr_x),
        .wr_y       (wr_y),
        .wr_val     (wr_val),
        .wr_ready   (wr_ready),
        .wr_done    (wr_done),
        .clr_go     (clr_go),
        .clr_lvl    (clr_lvl),
        .clr_busy   (clr_busy),
        .fetch_stb  (fetch_stb),
        .fetch_band (fetch_band),
        .fetch_row  (fetch_row),
        .fetch_col  (fetch_col),
        .we         (bank_we),
        .wdata      (bank_wdata)
    );

    bank_store #(.IB(IB_BITS)) u_banks (
        .clk       (clk),
        .fetch_stb (fetch_stb),
        .band      (fetch_band),
        .row       (fetch_row),
        .col       (fetch_col),
        .we        (bank_we),
        .wdata     (bank_wdata),
        .rdata     (bank_rdata)
    );

    pixel_shifter u_shift (
        .clk         (clk),
        .rst         (rst),
        .fetch_stb   (fetch_stb),
        .fetch_slot  (fetch_slot),
        .fill        (bank_rdata),
        .cur_phase   (cur_phase),
        .cur_slot    (cur_slot),
        .cur_live    (cur_live),
        .line_start  (line_start),
        .frame_start (frame_start),
        .beat        (beat)
    );

    assign video      = beat.pix;
    assign line_sync  = beat.line;
    assign frame_sync = beat.frame;

    // R4: a frame start is always also a line start
    p_frame_on_line_r4: assert property (@(posedge clk) disable iff (rst)
        frame_sync |-> line_sync);

    // R4: line pulses last a single cycle
    p_line_single_r4: assert property (@(posedge clk) disable iff (rst)
        line_sync |=> !line_sync);

endmodule

// File: tb/raster_scanner_bench.sv
module raster_scanner_bench;
    localparam int CLK_PERIOD = 10;
    localparam int IB    = 4;
    localparam int LINE  = 4 << IB;
    localparam int VROWS = 3 << IB;
    localparam int FRAME = LINE * (4 << IB);
    localparam int NWR   = 13;

    // {val, y, x}
    localparam logic [12:0] WR_TAB [NWR] = '{
        {1'b1, 6'd0,  6'd0},  {1'b1, 6'd0,  6'd63}, {1'b1, 6'd47, 6'd0},
        {1'b1, 6'd47, 6'd63}, {1'b1, 6'd17, 6'd5},  {1'b1, 6'd5,  6'd17},
        {1'b1, 6'd20, 6'd20}, {1'b0, 6'd20, 6'd20}, {1'b1, 6'd20, 6'd21},
        {1'b1, 6'd50, 6'd7},  {1'b1, 6'd31, 6'd62}, {1'b1, 6'd63, 6'd35},
        {1'b1, 6'd40, 6'd33}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic origin_bottom = 1'b0;
    logic wr_valid = 1'b0;
    logic [5:0] wr_x = '0;
    logic [5:0] wr_y = '0;
    logic wr_val = 1'b0;
    logic wr_ready, wr_done;
    logic clr_go = 1'b0;
    logic clr_lvl = 1'b0;
    logic clr_busy, video, line_sync, frame_sync;

    bit img [VROWS*LINE];
    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    raster_scanner #(.IB_BITS(IB)) u_raster_scanner (
        .clk(clk), .rst(rst), .origin_bottom(origin_bottom),
        .wr_valid(wr_valid), .wr_x(wr_x), .wr_y(wr_y), .wr_val(wr_val),
        .wr_ready(wr_ready), .wr_done(wr_done),
        .clr_go(clr_go), .clr_lvl(clr_lvl), .clr_busy(clr_busy),
        .video(video), .line_sync(line_sync), .frame_sync(frame_sync)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic run_clear(input bit lvl, input bit with_write);
        int n = 0;
        bit saw_done = 1'b0;
        clr_lvl = lvl;
        clr_go  = 1'b1;
        tick();
        clr_go = 1'b0;
        while (clr_busy && n < FRAME + 16) begin
            n++;
            if (n == 3) begin clr_go = 1'b1; clr_lvl = ~lvl; end
            if (n == 4) begin clr_go = 1'b0; clr_lvl = lvl; end
            if (with_write && n == 8) begin
                wr_x = 6'd10; wr_y = 6'd10; wr_val = 1'b1; wr_valid = 1'b1;
            end
            if (with_write && n == 9) begin
                wr_valid = 1'b0;
                chk("R6", "ready low while pending", int'(wr_ready), 0);
            end
            if (wr_done) saw_done = 1'b1;
            tick();
        end
        chk("R9", "clear busy length", n, FRAME);
        for (int i = 0; i < VROWS*LINE; i++) img[i] = lvl;
        if (with_write) begin
            int k = 0;
            chk("R10", "no commit during clear", int'(saw_done), 0);
            while (!wr_done && k < FRAME + 16) begin k++; tick(); end
            chk("R10", "deferred write acknowledged", int'(wr_done), 1);
            img[10*LINE + 10] = 1'b1;
            tick();
        end
    endtask

    task automatic write_px(input int x, input int y, input bit v);
        int k = 0;
        while (!wr_ready && k < FRAME + 16) begin k++; tick(); end
        wr_x = 6'(x); wr_y = 6'(y); wr_val = v; wr_valid = 1'b1;
        tick();
        wr_valid = 1'b0;
        chk("R6", "ready drops after accept", int'(wr_ready), 0);
        k = 0;
        while (!wr_done && k < FRAME + 16) begin k++; tick(); end
        chk("R6", "done within one period", int'(wr_done && k <= FRAME + 2), 1);
        tick();
        chk("R6", "done is one cycle", int'(wr_done), 0);
        if (y < VROWS) img[y*LINE + x] = v;
    endtask

    task automatic check_frame(input bit flip);
        int k = 0;
        while (!frame_sync && k < 2*FRAME) begin k++; tick(); end
        chk("R4", "frame pulse found", int'(frame_sync), 1);
        for (int n = 0; n < FRAME; n++) begin
            int ys = n / LINE;
            int x  = n % LINE;
            int e  = 0;
            if (ys < VROWS) e = img[(flip ? (VROWS - 1 - ys) : ys)*LINE + x];
            if (flip) chk("R11", "mirrored pixel", int'(video), e);
            else      chk("R1 R3 R5 R7 R8", "pixel", int'(video), e);
            chk("R4", "line pulse", int'(line_sync), int'(x == 0));
            chk("R4", "frame pulse", int'(frame_sync), int'(n == 0));
            tick();
        end
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog R6 actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        // R2: reset state
        chk("R2", "video in reset", int'(video), 0);
        chk("R2", "line_sync in reset", int'(line_sync), 0);
        chk("R2", "frame_sync in reset", int'(frame_sync), 0);
        chk("R2", "wr_ready in reset", int'(wr_ready), 1);
        chk("R2", "wr_done in reset", int'(wr_done), 0);
        chk("R2", "clr_busy in reset", int'(clr_busy), 0);
        rst = 1'b0;
        tick();

        // R9: bright clear, ignored second request, whole frame bright
        run_clear(1'b1, 1'b0);
        check_frame(1'b0);

        // R10: dark clear with a write issued during it
        run_clear(1'b0, 1'b1);

        // R1 R6 R7 R8: table of pixel writes
        for (int i = 0; i < NWR; i++)
            write_px(int'(WR_TAB[i][5:0]), int'(WR_TAB[i][11:6]), WR_TAB[i][12]);
        check_frame(1'b0);

        // R11: bottom origin
        origin_bottom = 1'b1;
        repeat (8) tick();
        check_frame(1'b1);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule